// File: doc/BRIEF.md
# Sector Flash Program and Erase Sequencer

This block runs the embedded write algorithms of a byte-wide nonvolatile memory model whose array is split into equal sectors. A command front end hands it already decoded requests: program one byte, mark a sector for erase, start erasing the marked sectors, erase the whole chip, suspend an erase, and resume it. The block times each operation with internal cycle counters. It applies the result to a small synthesizable storage array and refuses any change to a sector whose protect input is high.

An erase walks the marked sectors from the lowest index upward. For each sector it first drives every byte that is not yet zero down to zero, one byte per cycle. It then waits out the erase pulse, fills the sector with ones, and reads every byte back to confirm the fill. While an operation runs, a read returns a status byte in place of array data. Software learns that the operation has finished when two reads in a row agree, or when bit 7 shows the true value. An erase can be paused so that the other sectors can be read or programmed, and then continued. When an operation finishes, the block goes back to plain reads by itself.

Top module: `flash_seq`

## Requirements
- R1: After reset every byte of the array reads as all ones and reads return array data.
- R2: A program request (req_op 1) on an unprotected sector stores old AND new at that address after a timed delay. The block then returns to read mode without any further request.
- R3: While a program runs, bit 7 of any read is the complement of bit 7 of the data being programmed. While an erase runs, bit 7 reads 0. The remaining low bits of a status read are 0.
- R4: Bit 6 of consecutive status reads alternates between 1 and 0.
- R5: A sector whose sect_prot bit is high is never changed by program, sector erase or chip erase. A program request to it is ignored and leaves the block in read mode.
- R6: A mark request (req_op 2) adds the addressed sector to the erase set. A start request (req_op 3) erases every sector in the set to all ones and leaves unmarked sectors untouched.
- R7: A chip erase request (req_op 4) erases every unprotected sector.
- R8: Before its erase pulse, each erased sector is pre-programmed at one byte per cycle. A sector erase therefore stays busy for at least SECT_BYTES + ERASE_CYC cycles per sector.
- R9: A suspend request (req_op 5) during an erase pauses it. While paused, reads of sectors outside the erase set return array data, and reads inside the set return erase status.
- R10: While paused, a program to a sector outside the erase set runs normally, and the block then returns to the paused state.
- R11: While paused, a program to a sector inside the erase set is ignored and the block stays paused.
- R12: A resume request (req_op 6) continues the paused erase, and the erase then completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 3 | Request code: 1 program, 2 mark, 3 start erase, 4 chip erase, 5 suspend, 6 resume |
| req_addr | input | AW | Byte address; the top SW bits select the sector |
| req_data | input | DW | Program data |
| sect_prot | input | NUM_SECT | Per-sector write protect |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_data | output | DW | Array data or status byte |

## Verification
Most internal faults reach the ports within a few cycles. A wrong state decode makes rd_data switch between status and array data at the wrong moment, and this is visible on the very next read. Mistakes in the erase set or in the pre-program walk show up only when the erase ends: a sector holds old bytes, or the busy time is too short. Protection and suspend faults surface as changed bytes in sectors that should have been left alone, and these are read back once the block is idle again.

// File: rtl/flash_seq_pkg.sv
// Shared request codes and sequencer states.
package flash_seq_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_MARK   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_CHIP   = 3'd4,
        OP_SUSP   = 3'd5,
        OP_RESUME = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        S_READ, S_PROG, S_PICK, S_PRE, S_PULSE, S_VER, S_SUSP
    } st_e;
endpackage

// File: rtl/flash_seq_array.sv
// Storage array. Byte writes can only clear bits (AND). A sector fill sets a
// whole sector to ones in one cycle. Two combinational read ports.
// Assumes SECT_BYTES is a power of two.
module flash_seq_array #(
    parameter int NUM_SECT   = 8,
    parameter int SECT_BYTES = 8,
    parameter int DW         = 8,
    localparam int SW = $clog2(NUM_SECT),
    localparam int BW = $clog2(SECT_BYTES),
    localparam int AW = SW + BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_we,
    input  logic [AW-1:0] byte_addr,
    input  logic [DW-1:0] byte_data,
    input  logic          sect_we,
    input  logic [SW-1:0] sect_idx,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q,
    input  logic [AW-1:0] vf_addr,
    output logic [DW-1:0] vf_q
);
    localparam int DEPTH = NUM_SECT * SECT_BYTES;

    logic [DW-1:0] mem [DEPTH];

    // Reset to the erased state, then apply AND writes and sector fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            if (byte_we) mem[byte_addr] <= mem[byte_addr] & byte_data;
            if (sect_we)
                for (int i = 0; i < SECT_BYTES; i++)
                    mem[{sect_idx, BW'(i)}] <= '1;
        end
    end

    // Read ports.
    assign rd_q = mem[rd_addr];
    assign vf_q = mem[vf_addr];
endmodule

// File: rtl/flash_seq_timer.sv
// Pausable down counter. load sets it to CYC, and run counts it down toward
// zero. expired is high while the count is zero.
module flash_seq_timer #(
    parameter int CYC = 6,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt;

    // Load or count down.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= CW'(CYC);
        else if (run && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/flash_seq_status.sv
// Read output stage. It registers either array data or the status byte
// {b7, toggle, zeros}. The toggle flips after every status read.
module flash_seq_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          stat_sel,
    input  logic          stat_b7,
    input  logic [DW-1:0] arr_q,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic tog;

    // Capture the read result and advance the toggle on status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            tog      <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= stat_sel ? {stat_b7, tog, {(DW-2){1'b0}}} : arr_q;
                if (stat_sel) tog <= ~tog;
            end
        end
    end
endmodule

// File: rtl/flash_seq_ctrl.sv
// Sequencer FSM. It accepts decoded requests, keeps the erase set, walks
// pre-program, pulse and verify per sector, and handles suspend and resume.
// Assumes sect_prot is changed only while the block is in read mode.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int NUM_SECT   = 8,
    parameter int SECT_BYTES = 8,
    parameter int DW         = 8,
    localparam int SW = $clog2(NUM_SECT),
    localparam int BW = $clog2(SECT_BYTES),
    localparam int AW = SW + BW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_data,
    input  logic [NUM_SECT-1:0] sect_prot,
    input  logic [AW-1:0]       rd_addr,
    input  logic [DW-1:0]       vf_q,
    input  logic                p_exp,
    input  logic                e_exp,
    output logic                p_load,
    output logic                p_run,
    output logic                e_load,
    output logic                e_run,
    output logic                byte_we,
    output logic [AW-1:0]       byte_addr,
    output logic [DW-1:0]       byte_data,
    output logic                sect_we,
    output logic [SW-1:0]       sect_idx,
    output logic [AW-1:0]       vf_addr,
    output logic                stat_sel,
    output logic                stat_b7,
    output logic [NUM_SECT-1:0] mask_o
);
    st_e                 state, ret_st, sus_st;
    logic [NUM_SECT-1:0] mask;
    logic [SW-1:0]       cur, pick;
    logic [BW-1:0]       idx;
    logic [AW-1:0]       p_addr;
    logic [DW-1:0]       p_data;
    logic                any, last, erasing, susp_req, go_prog, vf_ok;
    logic [SW-1:0]       rsec, qsec;
    op_e                 op;

    assign op      = op_e'(req_op);
    assign qsec    = req_addr[AW-1 -: SW];
    assign rsec    = rd_addr[AW-1 -: SW];
    assign last    = (idx == BW'(SECT_BYTES - 1));
    assign vf_ok   = (vf_q == '1);
    assign erasing = (state == S_PICK) || (state == S_PRE) ||
                     (state == S_PULSE) || (state == S_VER);
    assign susp_req = req_valid && op == OP_SUSP && erasing;
    assign go_prog  = req_valid && op == OP_PROG && !sect_prot[qsec] &&
                      (state == S_READ || (state == S_SUSP && !mask[qsec]));

    // Lowest marked sector.
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = NUM_SECT - 1; i >= 0; i--)
            if (mask[i]) begin
                pick = SW'(i);
                any  = 1'b1;
            end
    end

    // Datapath and timer controls decoded from the state.
    always_comb begin
        vf_addr   = {cur, idx};
        p_load    = go_prog;
        p_run     = (state == S_PROG);
        e_load    = !susp_req && ((state == S_PRE && last) ||
                                  (state == S_VER && !vf_ok));
        e_run     = (state == S_PULSE);
        byte_we   = (state == S_PROG && p_exp) || (state == S_PRE && vf_q != '0);
        byte_addr = (state == S_PROG) ? p_addr : vf_addr;
        byte_data = (state == S_PROG) ? p_data : '0;
        sect_we   = (state == S_PULSE) && e_exp && !susp_req;
        sect_idx  = cur;
        stat_sel  = (state == S_PROG) || erasing || (state == S_SUSP && mask[rsec]);
        stat_b7   = (state == S_PROG) ? ~p_data[DW-1] : 1'b0;
        mask_o    = mask;
    end

    // State transitions, erase set and operand latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_READ;
            ret_st <= S_READ;
            sus_st <= S_PICK;
            mask   <= '0;
            cur    <= '0;
            idx    <= '0;
            p_addr <= '0;
            p_data <= '0;
        end else begin
            if (go_prog) begin
                p_addr <= req_addr;
                p_data <= req_data;
                ret_st <= state;
            end
            if (susp_req) begin
                sus_st <= state;
                state  <= S_SUSP;
            end else begin
                case (state)
                    S_READ: begin
                        if (go_prog) state <= S_PROG;
                        else if (req_valid) begin
                            case (op)
                                OP_MARK:  if (!sect_prot[qsec]) mask[qsec] <= 1'b1;
                                OP_ERASE: state <= S_PICK;
                                OP_CHIP: begin
                                    mask  <= ~sect_prot;
                                    state <= S_PICK;
                                end
                                default: ;
                            endcase
                        end
                    end
                    S_PROG: if (p_exp) state <= ret_st;
                    S_PICK: begin
                        if (!any)                 state <= S_READ;
                        else if (sect_prot[pick]) mask[pick] <= 1'b0;
                        else begin
                            cur   <= pick;
                            idx   <= '0;
                            state <= S_PRE;
                        end
                    end
                    S_PRE: begin
                        idx <= idx + 1'b1;
                        if (last) state <= S_PULSE;
                    end
                    S_PULSE: if (e_exp) begin
                        idx   <= '0;
                        state <= S_VER;
                    end
                    S_VER: begin
                        if (!vf_ok) state <= S_PULSE;
                        else if (last) begin
                            mask[cur] <= 1'b0;
                            state     <= S_PICK;
                        end else idx <= idx + 1'b1;
                    end
                    S_SUSP: begin
                        if (go_prog) state <= S_PROG;
                        else if (req_valid && op == OP_RESUME) state <= sus_st;
                    end
                    default: state <= S_READ;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_seq.sv
// Top level: sequencer, array, program and erase timers, read stage.
module flash_seq #(
    parameter int NUM_SECT   = 8,
    parameter int SECT_BYTES = 8,
    parameter int DW         = 8,
    parameter int PROG_CYC   = 6,
    parameter int ERASE_CYC  = 12,
    localparam int SW = $clog2(NUM_SECT),
    localparam int BW = $clog2(SECT_BYTES),
    localparam int AW = SW + BW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_data,
    input  logic [NUM_SECT-1:0] sect_prot,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic                rd_valid,
    output logic [DW-1:0]       rd_data
);
    logic                w_byte_we, w_sect_we, w_stat_sel, w_stat_b7;
    logic [AW-1:0]       w_byte_addr, w_vf_addr;
    logic [DW-1:0]       w_byte_data, w_vf_q, w_rd_q;
    logic [SW-1:0]       w_sect_idx;
    logic [NUM_SECT-1:0] w_mask;
    logic                p_load, p_run, p_exp, e_load, e_run, e_exp;

    flash_seq_ctrl #(.NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .sect_prot(sect_prot),
        .rd_addr(rd_addr), .vf_q(w_vf_q), .p_exp(p_exp), .e_exp(e_exp),
        .p_load(p_load), .p_run(p_run), .e_load(e_load), .e_run(e_run),
        .byte_we(w_byte_we), .byte_addr(w_byte_addr), .byte_data(w_byte_data),
        .sect_we(w_sect_we), .sect_idx(w_sect_idx), .vf_addr(w_vf_addr),
        .stat_sel(w_stat_sel), .stat_b7(w_stat_b7), .mask_o(w_mask));

    flash_seq_array #(.NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n), .byte_we(w_byte_we), .byte_addr(w_byte_addr),
        .byte_data(w_byte_data), .sect_we(w_sect_we), .sect_idx(w_sect_idx),
        .rd_addr(rd_addr), .rd_q(w_rd_q), .vf_addr(w_vf_addr), .vf_q(w_vf_q));

    flash_seq_timer #(.CYC(PROG_CYC)) u_ptmr (
        .clk(clk), .rst_n(rst_n), .load(p_load), .run(p_run), .expired(p_exp));

    flash_seq_timer #(.CYC(ERASE_CYC)) u_etmr (
        .clk(clk), .rst_n(rst_n), .load(e_load), .run(e_run), .expired(e_exp));

    flash_seq_status #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .stat_sel(w_stat_sel),
        .stat_b7(w_stat_b7), .arr_q(w_rd_q), .rd_valid(rd_valid), .rd_data(rd_data));
endmodule

// File: rtl/flash_seq_chk.sv
// Property checker for flash_seq, attached through bind.
module flash_seq_chk #(
    parameter int NUM_SECT   = 8,
    parameter int SECT_BYTES = 8,
    parameter int DW         = 8,
    localparam int SW = $clog2(NUM_SECT),
    localparam int BW = $clog2(SECT_BYTES),
    localparam int AW = SW + BW
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SECT-1:0] sect_prot,
    input logic                rd_en,
    input logic                rd_valid,
    input logic [DW-1:0]       rd_data,
    input logic                w_byte_we,
    input logic [AW-1:0]       w_byte_addr,
    input logic                w_sect_we,
    input logic [SW-1:0]       w_sect_idx,
    input logic                w_stat_sel,
    input logic [NUM_SECT-1:0] w_mask
);
    logic stat_q, have_prev, prev6;

    // Track whether the current result is a status read, and the last bit 6.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= 1'b0;
            have_prev <= 1'b0;
            prev6     <= 1'b0;
        end else begin
            stat_q <= rd_en && w_stat_sel;
            if (rd_valid && stat_q) begin
                have_prev <= 1'b1;
                prev6     <= rd_data[DW-2];
            end
        end
    end

    a_r5_no_byte_prot: assert property (@(posedge clk) disable iff (!rst_n)
        w_byte_we |-> !sect_prot[w_byte_addr[AW-1 -: SW]]);

    a_r5_no_fill_prot: assert property (@(posedge clk) disable iff (!rst_n)
        w_sect_we |-> !sect_prot[w_sect_idx]);

    a_r6_fill_marked: assert property (@(posedge clk) disable iff (!rst_n)
        w_sect_we |-> w_mask[w_sect_idx]);

    a_r4_toggle_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && stat_q && have_prev) |-> (rd_data[DW-2] != prev6));
endmodule

bind flash_seq flash_seq_chk #(.NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES), .DW(DW)) u_chk (.*);

// File: tb/flash_seq_test.sv
module flash_seq_test;
    localparam int NS = 8, SB = 8, ERC = 12;

    logic       clk = 0, rst_n = 0;
    logic       req_valid = 0, rd_en = 0;
    logic [2:0] req_op = 0;
    logic [5:0] req_addr = 0, rd_addr = 0;
    logic [7:0] req_data = 0, rd_data;
    logic [7:0] sect_prot = 0;
    logic       rd_valid;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    logic [7:0] last_rd;

    typedef struct {bit chk; logic [7:0] exp; logic [7:0] msk; string tag;} item_t;
    item_t q[$];

    flash_seq #(.NUM_SECT(NS), .SECT_BYTES(SB), .PROG_CYC(6), .ERASE_CYC(ERC)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .sect_prot(sect_prot),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop the expected item for every returned read.
    always @(negedge clk) begin : mon
        item_t it;
        if (rst_n && rd_valid) begin
            if (q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read act=%h exp=none", rd_data);
            end else begin
                it = q.pop_front();
                if (it.chk) begin
                    checks++;
                    if ((rd_data & it.msk) != (it.exp & it.msk)) begin
                        errors++;
                        $display("FAIL %s act=%h exp=%h mask=%h", it.tag, rd_data, it.exp, it.msk);
                    end
                end
            end
            last_rd = rd_data;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Driver: queue the expectation, then issue the read.
    task automatic rd(input [5:0] a, input bit c, input [7:0] e, input [7:0] m,
                      input string t, output logic [7:0] v);
        q.push_back('{c, e, m, t});
        @(negedge clk) begin rd_en = 1; rd_addr = a; end
        @(negedge clk) rd_en = 0;
        #1 v = last_rd;
    endtask

    task automatic expect_rd(input [5:0] a, input [7:0] e, input string t);
        logic [7:0] v;
        rd(a, 1, e, 8'hFF, t, v);
    endtask

    task automatic req(input [2:0] o, input [5:0] a, input [7:0] d);
        @(negedge clk) begin req_valid = 1; req_op = o; req_addr = a; req_data = d; end
        @(negedge clk) begin req_valid = 0; req_op = 0; end
    endtask

    // Poll until two consecutive reads agree (toggle has stopped).
    task automatic wait_done(input [5:0] a, input string t);
        logic [7:0] v1, v2;
        int n = 0;
        do begin
            rd(a, 0, 0, 0, t, v1);
            rd(a, 0, 0, 0, t, v2);
            n += 2;
        end while (v1 != v2 && n < 400);
        check(n < 400, {t, " completes"}, n, 400);
    endtask

    task automatic prog(input [5:0] a, input [7:0] d);
        req(3'd1, a, d);
        wait_done(a, "R2 program done");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v1, v2;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        expect_rd(6'd0,  8'hFF, "R1 reset addr0");
        expect_rd(6'd17, 8'hFF, "R1 reset addr17");
        expect_rd(6'd63, 8'hFF, "R1 reset addr63");

        // R2/R3/R4: program with status polling
        req(3'd1, 6'd5, 8'hA5);
        rd(6'd5, 1, 8'h00, 8'hBF, "R3 program status b7", v1);
        rd(6'd5, 1, 8'h00, 8'h80, "R3 program status b7 again", v2);
        check(v1[6] != v2[6], "R4 toggle during program", v2[6], !v1[6]);
        wait_done(6'd5, "R2 program");
        expect_rd(6'd5, 8'hA5, "R2 program value");
        prog(6'd5, 8'h0F);
        expect_rd(6'd5, 8'h05, "R2 AND semantics");

        // Set up data in several sectors
        prog(6'd9,  8'h3C);
        prog(6'd18, 8'h42);
        prog(6'd25, 8'h11);
        prog(6'd33, 8'h77);
        sect_prot = 8'b0000_0100;

        // R5: program to protected sector ignored, no status
        req(3'd1, 6'd18, 8'h00);
        expect_rd(6'd18, 8'h42, "R5 protected program ignored");

        // R6/R8: multi-sector erase with a protected mark
        req(3'd2, 6'd9, 0);
        req(3'd2, 6'd18, 0);
        req(3'd2, 6'd25, 0);
        t0 = cyc;
        req(3'd3, 0, 0);
        rd(6'd9, 1, 8'h00, 8'h80, "R3 erase status b7", v1);
        rd(6'd9, 1, 8'h00, 8'h80, "R3 erase status b7 again", v2);
        check(v1[6] != v2[6], "R4 toggle during erase", v2[6], !v1[6]);
        wait_done(6'd9, "R6 erase");
        check((cyc - t0) >= 2 * (SB + ERC), "R8 erase busy time", cyc - t0, 2 * (SB + ERC));
        expect_rd(6'd9,  8'hFF, "R6 marked sector1 erased");
        expect_rd(6'd25, 8'hFF, "R6 marked sector3 erased");
        expect_rd(6'd33, 8'h77, "R6 unmarked sector4 kept");
        expect_rd(6'd5,  8'h05, "R6 unmarked sector0 kept");
        expect_rd(6'd18, 8'h42, "R5 protected sector kept on erase");

        // R9-R12: suspend and resume
        prog(6'd41, 8'h5A);
        prog(6'd49, 8'h99);
        req(3'd2, 6'd41, 0);
        req(3'd3, 0, 0);
        req(3'd5, 0, 0);
        expect_rd(6'd49, 8'h99, "R9 read non-erasing sector");
        rd(6'd41, 1, 8'h00, 8'hBF, "R9 erasing sector shows status", v1);
        req(3'd1, 6'd49, 8'hF0);
        wait_done(6'd49, "R10 program in suspend");
        expect_rd(6'd49, 8'h90, "R10 program in suspend value");
        rd(6'd41, 1, 8'h00, 8'h80, "R10 back to suspend", v1);
        req(3'd1, 6'd42, 8'h00);
        expect_rd(6'd49, 8'h90, "R11 ignored program, no busy");
        rd(6'd42, 1, 8'h00, 8'h80, "R11 still suspended", v1);
        req(3'd6, 0, 0);
        wait_done(6'd41, "R12 resumed erase");
        expect_rd(6'd41, 8'hFF, "R12 erase completed");
        expect_rd(6'd42, 8'hFF, "R11 erasing sector byte unprogrammed");
        expect_rd(6'd49, 8'h90, "R12 other sector kept");

        // R7: chip erase with protection
        req(3'd4, 0, 0);
        wait_done(6'd0, "R7 chip erase");
        expect_rd(6'd5,  8'hFF, "R7 chip erase sector0");
        expect_rd(6'd33, 8'hFF, "R7 chip erase sector4");
        expect_rd(6'd49, 8'hFF, "R7 chip erase sector6");
        expect_rd(6'd18, 8'h42, "R5 protected sector kept on chip erase");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule